// File: doc/BRIEF.md
# Serial-to-Parallel Latched Output Port

This block turns a serial bit stream from a host controller into a set of parallel output lines, as used in front of an LED driver stage. The host presents one data bit per shift, marked by a clock enable that stands for a rising edge of the serial shift clock. Once a full frame has been shifted in, the host drops an active-low strobe. While the strobe stays low, an output latch is transparent and copies the shift register. While it is high, the latch holds.

An active-low clear empties the latch at once, at any time, and wins over the strobe. It leaves the shift register as it is. An optional cascade output carries the bit leaving the last shift stage, so several ports can share one serial line in a chain. An optional output enable can force every parallel line low without losing what the latch holds. The width is a parameter, meant for 8, 12, 16 or 24 lines.

Top module: `sipo_latch_port`

## Requirements
- R1: On each rising `clk` edge with `shift_en` high, stage 0 (nearest the serial input) takes `sdi` and every stage k takes the old value of stage k-1. With `shift_en` low the shift register keeps its value.
- R2: While `stb_n` is low and `clr_n` is high, the latch is transparent: its contents, and `par_out` when enabled, follow the shift register, including through shifts made while the strobe is held low.
- R3: While `stb_n` is high, the latch and `par_out` keep their value whatever is shifted in.
- R4: When `clr_n` is low, the latch and every bit of `par_out` go to 0 at once, without waiting for a clock edge, and stay 0 even while `stb_n` is low.
- R5: `clr_n` does not touch the shift register: after a clear, a strobe shows the bits that were shifted in before it.
- R6: With `CASCADE` set to `CASC_LAST`, `sdo` equals the last shift stage and changes only on a rising `clk` edge with `shift_en` high, whatever `stb_n` does; with `CASC_NONE`, `sdo` is 0.
- R7: With `GATE` set to `GATE_ENABLE`, `out_en` low forces all of `par_out` to 0 and `out_en` high shows the latch; the latch contents survive a period with `out_en` low.
- R8: Bit order: of a frame of `WIDTH` bits, the first bit shifted in appears on output line `WIDTH` (`par_out[WIDTH-1]`) and the last on line 1 (`par_out[0]`).
- R9: Two ports chained through `sdo` into `sdi` and given 2*`WIDTH` shifts hold the first `WIDTH` bits in the downstream port and the last `WIDTH` bits in the upstream port.
- R10: With `WIDTH` set to 8, 12, 16 or 24, a 24-bit stream sent most significant bit first leaves each port showing the low `WIDTH` bits of that stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edges with `shift_en` high are shift edges |
| clr_n | input | 1 | Active-low asynchronous clear of the output latch |
| shift_en | input | 1 | Clock enable standing for a rising edge of the serial shift clock |
| sdi | input | 1 | Serial data input |
| stb_n | input | 1 | Active-low strobe; latch is transparent while low |
| out_en | input | 1 | Active-high output enable (unused when `GATE` is `GATE_NONE`) |
| par_out | output | WIDTH | Parallel output lines; line n is bit n-1 |
| sdo | output | 1 | Cascade output from the last shift stage |

## Verification
On every clock edge the assertions check the shift step and the hold with the enable low, the latch following the shift register while the strobe is low and holding while it is high, all-zero outputs during a clear, the one-shift lag of the cascade output, and the effect of the output enable. Only the bench's scenarios can show that the clear acts between clock edges, that the shift register survives a clear, that the latch keeps its value through a disabled period, that bit order comes out right for each width, and that a two-port chain splits a double-length stream correctly.

// File: rtl/sipo_pkg.sv
`timescale 1ns/1ps
package sipo_pkg;

  // Whether the last shift stage is brought out for chaining.
  typedef enum logic {
    CASC_NONE = 1'b0,
    CASC_LAST = 1'b1
  } casc_mode_e;

  // Whether the parallel outputs pass through an enable gate.
  typedef enum logic {
    GATE_NONE   = 1'b0,
    GATE_ENABLE = 1'b1
  } gate_mode_e;

endpackage

// File: rtl/sipo_shift_chain.sv
`timescale 1ns/1ps
module sipo_shift_chain #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             shift_en,
  input  logic             sdi,
  output logic [WIDTH-1:0] sr_q
);

  localparam int TOP = WIDTH - 1;

  logic [TOP:0] sr_d;

  // Next state: stage 0 takes the serial bit, the rest move up by one.
  always_comb begin
    sr_d = sr_q;
    if (shift_en) begin
      sr_d = {sr_q[TOP-1:0], sdi};
    end
  end

  // The chain has no reset: the clear acts on the latch only.
  always_ff @(posedge clk) begin
    sr_q <= sr_d;
  end

endmodule

// File: rtl/sipo_hold_latch.sv
`timescale 1ns/1ps
module sipo_hold_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clr_n,
  input  logic             stb_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  // Level-sensitive storage; the clear wins over the strobe.
  always_latch begin
    if (!clr_n) begin
      q <= '0;
    end else if (!stb_n) begin
      q <= d;
    end
  end

endmodule

// File: rtl/sipo_out_gate.sv
`timescale 1ns/1ps
module sipo_out_gate #(
  parameter int                   WIDTH = 8,
  parameter sipo_pkg::gate_mode_e GATE  = sipo_pkg::GATE_ENABLE
) (
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  if (GATE == sipo_pkg::GATE_ENABLE) begin : g_gated
    assign q = d & {WIDTH{en}};
  end else begin : g_direct
    logic unused_en;
    assign unused_en = en;
    assign q = d;
  end

endmodule

// File: rtl/sipo_latch_port.sv
`timescale 1ns/1ps
module sipo_latch_port #(
  parameter int                   WIDTH   = 8,
  parameter sipo_pkg::casc_mode_e CASCADE = sipo_pkg::CASC_LAST,
  parameter sipo_pkg::gate_mode_e GATE    = sipo_pkg::GATE_ENABLE
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             shift_en,
  input  logic             sdi,
  input  logic             stb_n,
  input  logic             out_en,
  output logic [WIDTH-1:0] par_out,
  output logic             sdo
);

  localparam int TOP  = WIDTH - 1;
  localparam int NEXT = WIDTH - 2;

  logic [TOP:0] sr_q;
  logic [TOP:0] lat_q;

  sipo_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk      (clk),
    .shift_en (shift_en),
    .sdi      (sdi),
    .sr_q     (sr_q)
  );

  sipo_hold_latch #(.WIDTH(WIDTH)) u_latch (
    .clr_n (clr_n),
    .stb_n (stb_n),
    .d     (sr_q),
    .q     (lat_q)
  );

  sipo_out_gate #(.WIDTH(WIDTH), .GATE(GATE)) u_gate (
    .en (out_en),
    .d  (lat_q),
    .q  (par_out)
  );

  if (CASCADE == sipo_pkg::CASC_LAST) begin : g_casc
    assign sdo = sr_q[TOP];

    // R6: the cascade bit is the one that sat one stage below last
    assert_casc_lag_R6: assert property (@(posedge clk) disable iff (!clr_n)
      shift_en |=> sdo == $past(sr_q[NEXT]));
    assert_casc_still_R6: assert property (@(posedge clk) disable iff (!clr_n)
      !shift_en |=> $stable(sdo));
  end else begin : g_no_casc
    assign sdo = 1'b0;
  end

  if (GATE == sipo_pkg::GATE_ENABLE) begin : g_gate_chk
    // R7: disabled outputs read zero, enabled outputs show the latch
    assert_gate_off_R7: assert property (@(posedge clk) disable iff (!clr_n)
      !out_en |-> par_out == '0);
    assert_gate_on_R7: assert property (@(posedge clk) disable iff (!clr_n)
      out_en |-> par_out == lat_q);
  end

  // R1: one-stage move with the serial bit entering stage 0
  assert_shift_step_R1: assert property (@(posedge clk) disable iff (!clr_n)
    shift_en |=> sr_q == {$past(sr_q[NEXT:0]), $past(sdi)});
  assert_shift_idle_R1: assert property (@(posedge clk) disable iff (!clr_n)
    !shift_en |=> $stable(sr_q));

  // R2: transparent latch while the strobe is low
  assert_transparent_R2: assert property (@(posedge clk) disable iff (!clr_n)
    !stb_n |-> lat_q == sr_q);

  // R3: latch holds across edges with the strobe high
  assert_hold_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (stb_n && $past(stb_n)) |-> $stable(lat_q));

  // R4: clear forces latch and outputs to zero regardless of the strobe
  assert_clear_zero_R4: assert property (@(posedge clk)
    !clr_n |-> (lat_q == '0 && par_out == '0));

endmodule

// File: tb/test_sipo_latch_port.sv
`timescale 1ns/1ps
module test_sipo_latch_port;
  import sipo_pkg::*;

  logic        clk;
  logic        clr_n;
  logic        shift_en;
  logic        sdi;
  logic        stb_n;
  logic        out_en;
  logic [7:0]  p8, p8b;
  logic [11:0] p12;
  logic [15:0] p16;
  logic [23:0] p24;
  logic        sdo8, sdo8b, sdo12, sdo16, sdo24;

  int checks;
  int failures;

  // Table entries: {out_en, byte shifted MSB first, expected par_out}
  localparam logic [16:0] VEC [6] = '{
    {1'b1, 8'hA5, 8'hA5},
    {1'b1, 8'h01, 8'h01},
    {1'b1, 8'h80, 8'h80},
    {1'b0, 8'h3C, 8'h00},
    {1'b1, 8'hFF, 8'hFF},
    {1'b1, 8'h00, 8'h00}
  };

  sipo_latch_port #(.WIDTH(8)) i_sipo_latch_port (
    .clk(clk), .clr_n(clr_n), .shift_en(shift_en), .sdi(sdi),
    .stb_n(stb_n), .out_en(out_en), .par_out(p8), .sdo(sdo8));

  sipo_latch_port #(.WIDTH(8)) i_sipo_latch_port_down (
    .clk(clk), .clr_n(clr_n), .shift_en(shift_en), .sdi(sdo8),
    .stb_n(stb_n), .out_en(out_en), .par_out(p8b), .sdo(sdo8b));

  sipo_latch_port #(.WIDTH(12), .CASCADE(CASC_NONE), .GATE(GATE_NONE)) i_sipo_latch_port_w12 (
    .clk(clk), .clr_n(clr_n), .shift_en(shift_en), .sdi(sdi),
    .stb_n(stb_n), .out_en(out_en), .par_out(p12), .sdo(sdo12));

  sipo_latch_port #(.WIDTH(16)) i_sipo_latch_port_w16 (
    .clk(clk), .clr_n(clr_n), .shift_en(shift_en), .sdi(sdi),
    .stb_n(stb_n), .out_en(out_en), .par_out(p16), .sdo(sdo16));

  sipo_latch_port #(.WIDTH(24)) i_sipo_latch_port_w24 (
    .clk(clk), .clr_n(clr_n), .shift_en(shift_en), .sdi(sdi),
    .stb_n(stb_n), .out_en(out_en), .par_out(p24), .sdo(sdo24));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Shift n bits of v, most significant first; returns at a falling edge.
  task automatic shift_bits(input logic [23:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      sdi      = v[i];
      shift_en = 1'b1;
    end
    @(negedge clk);
    shift_en = 1'b0;
  endtask

  // Strobe low for one full cycle; no shifting meanwhile.
  task automatic strobe_pulse;
    @(negedge clk);
    stb_n = 1'b0;
    @(negedge clk);
    stb_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks   = 0;
    failures = 0;
    clr_n    = 1'b0;
    shift_en = 1'b0;
    sdi      = 1'b0;
    stb_n    = 1'b1;
    out_en   = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R4 reset 8-bit outputs", 32'(p8), 32'h0);
    check("R4 reset 24-bit outputs", 32'(p24), 32'h0);
    @(negedge clk);
    clr_n = 1'b1;

    // Table walk: main function under several byte patterns (R2, R7, R8)
    for (int k = 0; k < 6; k++) begin
      out_en = VEC[k][16];
      shift_bits({16'h0, VEC[k][15:8]}, 8);
      stb_n = 1'b0;
      #1;
      check("R2/R8 table vector", 32'(p8), 32'(VEC[k][7:0]));
      @(negedge clk);
      stb_n = 1'b1;
    end
    out_en = 1'b1;

    // R3: shifting with strobe high leaves outputs alone
    shift_bits(24'h5A, 8);
    #1;
    check("R3 hold while strobe high", 32'(p8), 32'h00);
    strobe_pulse();
    #1;
    check("R2 strobe loads 5A", 32'(p8), 32'h5A);

    // R2: shift while the strobe is held low
    @(negedge clk);
    stb_n = 1'b0;
    shift_bits(24'h1, 1);
    #1;
    check("R2 transparent through shift", 32'(p8), 32'hB5);
    stb_n = 1'b1;
    shift_bits(24'h0, 1);
    #1;
    check("R3 hold after strobe release", 32'(p8), 32'hB5);

    // R4: clear mid-strobe, between clock edges, wins over the strobe
    @(negedge clk);
    stb_n = 1'b0;
    #1;
    check("R2 strobe shows 6A", 32'(p8), 32'h6A);
    @(negedge clk);
    clr_n = 1'b0;
    #1;
    check("R4 async clear during strobe", 32'(p8), 32'h00);
    @(negedge clk);
    check("R4 clear priority after edge", 32'(p8), 32'h00);
    clr_n = 1'b1;
    #1;
    check("R5 shift register kept through clear", 32'(p8), 32'h6A);
    @(negedge clk);
    stb_n = 1'b1;

    // R4/R5: clear with strobe high, then strobe restores shifted data
    @(negedge clk);
    clr_n = 1'b0;
    #1;
    check("R4 clear with strobe high", 32'(p8), 32'h00);
    @(negedge clk);
    clr_n = 1'b1;
    #1;
    check("R4 latch stays clear after release", 32'(p8), 32'h00);
    strobe_pulse();
    #1;
    check("R5 strobe after clear", 32'(p8), 32'h6A);

    // R7: output enable gates without losing the latch
    @(negedge clk);
    out_en = 1'b0;
    #1;
    check("R7 outputs forced low", 32'(p8), 32'h00);
    @(negedge clk);
    out_en = 1'b1;
    #1;
    check("R7 latch value returns", 32'(p8), 32'h6A);

    // R6: cascade output timing (byte 93 -> last stage 1, then 0)
    shift_bits(24'h93, 8);
    #1;
    check("R6 sdo shows last stage", 32'(sdo8), 32'h1);
    check("R6 no-cascade variant drives 0", 32'(sdo12), 32'h0);
    @(negedge clk);
    sdi      = 1'b1;
    shift_en = 1'b1;
    #1;
    check("R6 sdo unchanged before rising edge", 32'(sdo8), 32'h1);
    @(negedge clk);
    shift_en = 1'b0;
    #1;
    check("R6 sdo after rising edge", 32'(sdo8), 32'h0);
    @(negedge clk);
    #1;
    check("R6 sdo stable without shift", 32'(sdo8), 32'h0);

    // R9: two-port chain takes 16 bits
    shift_bits(24'hE17B, 16);
    strobe_pulse();
    #1;
    check("R9 upstream port", 32'(p8), 32'h7B);
    check("R9 downstream port", 32'(p8b), 32'hE1);

    // R8/R10: bit order for every width from one 24-bit stream
    shift_bits(24'h9A3C57, 24);
    strobe_pulse();
    #1;
    check("R10 width 24", 32'(p24), 32'h9A3C57);
    check("R10 width 16", 32'(p16), 32'h3C57);
    check("R10 width 12", 32'(p12), 32'hC57);
    check("R8 width 8", 32'(p8), 32'h57);
    check("R8 output 1 is last bit", 32'(p24[0]), 32'h1);
    check("R8 output 24 is first bit", 32'(p24[23]), 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule